// File: doc/BRIEF.md
# Transmit descriptor DMA channel

This block is one transmit DMA channel. Software builds a chain of descriptors in memory, points the channel at the first one and starts it. The channel reads each descriptor and checks that the engine owns it. It then reads the packet payload in bursts of a programmable size and streams the words to a peripheral over a ready/valid interface, reversing the byte order of each word if asked to. When the last word of a packet has been taken, the channel hands the descriptor back to software, pulses a done interrupt and follows the next pointer.

When the channel reads a descriptor that it does not own, it raises a separate end interrupt, which covers both the end of the chain and an underrun. It then stops and leaves the descriptor pointer on that descriptor, so that starting the channel again picks up from the same place.

The memory port is a request/grant port with a length field. A read request of N words is followed, after the grant, by N data beats marked by `mem_rvalid_i`. A write request carries one word and completes on its grant. Addresses are byte addresses and words are 4 bytes apart.

Top module: `tx_dma_chan`

## Requirements
- R1: During and after reset the channel is stopped. No memory request, stream word or interrupt is active, and the pointer, start, burst and swap registers all read 0.
- R2: The register offsets are 0x00 (descriptor pointer), 0x04 (start; write 1 to run, write 0 to stop; reads the running bit), 0x0C (burst code, 2 bits) and 0x18 (swap enable, 1 bit). Reads return the register value zero-extended, and any other offset reads 0.
- R3: A descriptor is four words at the pointer address, fetched as one 4-word read. Word 0 holds ownership in bits [1:0] (0 = software, 1 = engine, other values treated as not owned) and the length in words in bits [31:16]. Word 1 is the next-descriptor address, word 2 is the buffer address and word 3 is unused.
- R4: On a descriptor it does not own, the channel pulses `end_irq_o` for one cycle, clears the running bit and keeps the pointer unchanged. Writing 1 to start then fetches that same descriptor again.
- R5: Burst code 0, 1 and 2 select 4, 8 and 16 words, and code 3 also selects 16. Payload reads cover the buffer at rising addresses, each with a length of the burst size or the words that remain, whichever is smaller.
- R6: Payload words leave on `tx_data_o` in buffer order, with `tx_last_o` set on the final word of each packet. A word and its last flag hold steady while `tx_valid_o` is high and `tx_ready_i` is low.
- R7: With swap enabled, each 32-bit word leaves with its four bytes in reverse order. With swap disabled, words pass through unchanged.
- R8: After the final word of a packet is accepted, the channel writes word 0 back to the descriptor address as a 1-word write, with bits [1:0] cleared and the length kept. It then pulses `done_irq_o` for one cycle and loads the next-descriptor address into the pointer. Done and end pulses never coincide.
- R9: A write to the pointer register is ignored while the channel is running or still finishing a packet, and is accepted once it is stopped and idle.
- R10: Writing 0 to start lets the packet in progress complete, with its write-back and done pulse. No further descriptor is fetched and no end interrupt is raised.
- R11: A zero-length owned descriptor causes no payload read and no stream word. It is still written back and still produces a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| mem_req_o | output | 1 | Memory request, held until granted |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Request byte address |
| mem_len_o | output | 5 | Request length in words |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data beat valid |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Stream word valid |
| tx_ready_i | input | 1 | Peripheral accepts word |
| tx_data_o | output | 32 | Stream word |
| tx_last_o | output | 1 | Final word of packet |
| done_irq_o | output | 1 | Packet transmitted pulse |
| end_irq_o | output | 1 | Not-owned descriptor (end or underrun) pulse |

## Verification
The bench goes after the burst split at the tail of a packet: lengths of 5, 9, 3 and 20 words against all three burst sizes. A design that rounds the last burst up would read past the buffer, and one that drops it would short the packet. A chain ending in a software-owned descriptor checks that the end pulse comes after the last done pulse and that the pointer stays put. Restarting the channel then checks that the same descriptor is fetched again; a design that advanced the pointer would skip that packet. With the stream stalled, a pointer write must read back unchanged and a stop must still let the packet finish, so a design that aborted would lose words and one that ran on would fetch the following descriptor. A zero-length descriptor catches a design that issues an empty read or waits forever for a last word.

// File: rtl/tx_dma_pkg.sv
package tx_dma_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned RA_W     = 5;
  localparam int unsigned LEN_W    = 16;
  localparam int unsigned LEN_LSB  = 16;
  localparam int unsigned MLEN_W   = 5;
  localparam int unsigned DESC_WDS = 4;

  localparam logic [RA_W-1:0] OFF_PTR   = 5'h00;
  localparam logic [RA_W-1:0] OFF_RUN   = 5'h04;
  localparam logic [RA_W-1:0] OFF_BURST = 5'h0C;
  localparam logic [RA_W-1:0] OFF_SWAP  = 5'h18;

  localparam logic [1:0] OWN_ENG = 2'd1;

  typedef enum logic [2:0] {
    S_IDLE, S_DREQ, S_DRD, S_CHECK, S_PREQ, S_PRD, S_DRAIN, S_WB
  } eng_st_e;

  function automatic logic [MLEN_W-1:0] burst_words(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/tx_dma_regs.sv
module tx_dma_regs
  import tx_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [RA_W-1:0]     addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   rdata_o,
  input  logic                eng_idle_i,
  input  logic                ptr_upd_i,
  input  logic [ADDR_W-1:0]   ptr_nxt_i,
  input  logic                eng_end_i,
  output logic [ADDR_W-1:0]   ptr_o,
  output logic                run_o,
  output logic [1:0]          burst_o,
  output logic                swap_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic              run_q;
  logic [1:0]        burst_q;
  logic              swap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      run_q   <= 1'b0;
      burst_q <= 2'd0;
      swap_q  <= 1'b0;
    end else begin
      if (ptr_upd_i)
        ptr_q <= ptr_nxt_i;
      else if (we_i && addr_i == OFF_PTR && !run_q && eng_idle_i)
        ptr_q <= wdata_i[ADDR_W-1:0];
      // engine stop wins over a same-cycle software start
      if (eng_end_i)
        run_q <= 1'b0;
      else if (we_i && addr_i == OFF_RUN)
        run_q <= wdata_i[0];
      if (we_i && addr_i == OFF_BURST) burst_q <= wdata_i[1:0];
      if (we_i && addr_i == OFF_SWAP)  swap_q  <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_PTR:   rdata_o[ADDR_W-1:0] = ptr_q;
      OFF_RUN:   rdata_o[0]          = run_q;
      OFF_BURST: rdata_o[1:0]        = burst_q;
      OFF_SWAP:  rdata_o[0]          = swap_q;
      default:   rdata_o             = '0;
    endcase
  end

  assign ptr_o   = ptr_q;
  assign run_o   = run_q;
  assign burst_o = burst_q;
  assign swap_o  = swap_q;
endmodule

// File: rtl/tx_dma_fifo.sv
module tx_dma_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [W-1:0]                 pdata_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 head_o,
  output logic                         empty_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= pdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
endmodule

// File: rtl/tx_dma_engine.sv
module tx_dma_engine
  import tx_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              run_i,
  input  logic [ADDR_W-1:0]                 ptr_i,
  input  logic [1:0]                        burst_i,
  input  logic                              swap_i,
  output logic                              mem_req_o,
  output logic                              mem_we_o,
  output logic [ADDR_W-1:0]                 mem_addr_o,
  output logic [MLEN_W-1:0]                 mem_len_o,
  output logic [WORD_W-1:0]                 mem_wdata_o,
  input  logic                              mem_gnt_i,
  input  logic                              mem_rvalid_i,
  input  logic [WORD_W-1:0]                 mem_rdata_i,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_count_i,
  output logic                              push_o,
  output logic [WORD_W:0]                   push_data_o,
  output logic                              idle_o,
  output logic                              ptr_upd_o,
  output logic [ADDR_W-1:0]                 ptr_nxt_o,
  output logic                              end_o,
  output logic                              done_irq_o,
  output logic                              end_irq_o
);
  eng_st_e             st_q;
  logic [WORD_W-1:0]   stat_q;
  logic [ADDR_W-1:0]   next_q, cur_q;
  logic [LEN_W-1:0]    rem_q;
  logic [MLEN_W-1:0]   beat_q;
  logic [1:0]          bidx_q;
  logic                done_q, end_q;

  logic [MLEN_W-1:0]   bw, blen;
  logic                room_ok, owned;
  logic [WORD_W-1:0]   swapped;

  for (genvar b = 0; b < 4; b++) begin : g_swap
    assign swapped[8*b +: 8] = mem_rdata_i[8*(3-b) +: 8];
  end

  assign bw      = burst_words(burst_i);
  assign blen    = (rem_q < {{(LEN_W-MLEN_W){1'b0}}, bw}) ? rem_q[MLEN_W-1:0] : bw;
  assign room_ok = (FIFO_DEPTH - int'(fifo_count_i)) >= int'(blen);
  assign owned   = (stat_q[1:0] == OWN_ENG);

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr_i;
    mem_len_o   = MLEN_W'(DESC_WDS);
    mem_wdata_o = '0;
    case (st_q)
      S_DREQ: mem_req_o = 1'b1;
      S_PREQ: begin
        mem_req_o  = room_ok;
        mem_addr_o = cur_q;
        mem_len_o  = blen;
      end
      S_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_len_o   = 5'd1;
        mem_wdata_o = {stat_q[WORD_W-1:2], 2'b00};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      stat_q <= '0;
      next_q <= '0;
      cur_q  <= '0;
      rem_q  <= '0;
      beat_q <= '0;
      bidx_q <= '0;
      done_q <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      end_q  <= 1'b0;
      case (st_q)
        S_IDLE: if (run_i) st_q <= S_DREQ;
        S_DREQ: if (mem_gnt_i) begin
          bidx_q <= '0;
          st_q   <= S_DRD;
        end
        S_DRD: if (mem_rvalid_i) begin
          case (bidx_q)
            2'd0:    stat_q <= mem_rdata_i;
            2'd1:    next_q <= mem_rdata_i[ADDR_W-1:0];
            2'd2:    cur_q  <= mem_rdata_i[ADDR_W-1:0];
            default: ;
          endcase
          bidx_q <= bidx_q + 2'd1;
          if (bidx_q == 2'd3) st_q <= S_CHECK;
        end
        S_CHECK: begin
          if (!owned) begin
            end_q <= 1'b1;
            st_q  <= S_IDLE;
          end else begin
            rem_q <= stat_q[LEN_LSB +: LEN_W];
            st_q  <= (stat_q[LEN_LSB +: LEN_W] == '0) ? S_WB : S_PREQ;
          end
        end
        S_PREQ: if (room_ok && mem_gnt_i) begin
          beat_q <= blen;
          rem_q  <= rem_q - {{(LEN_W-MLEN_W){1'b0}}, blen};
          cur_q  <= cur_q + ADDR_W'({blen, 2'b00});
          st_q   <= S_PRD;
        end
        S_PRD: if (mem_rvalid_i) begin
          beat_q <= beat_q - 5'd1;
          if (beat_q == 5'd1) st_q <= (rem_q == '0) ? S_DRAIN : S_PREQ;
        end
        S_DRAIN: if (fifo_count_i == '0) st_q <= S_WB;
        S_WB: if (mem_gnt_i) begin
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign push_o      = (st_q == S_PRD) && mem_rvalid_i;
  assign push_data_o = {(rem_q == '0) && (beat_q == 5'd1), swap_i ? swapped : mem_rdata_i};
  assign idle_o      = (st_q == S_IDLE);
  assign ptr_upd_o   = (st_q == S_WB) && mem_gnt_i;
  assign ptr_nxt_o   = next_q;
  assign end_o       = (st_q == S_CHECK) && !owned;
  assign done_irq_o  = done_q;
  assign end_irq_o   = end_q;
endmodule

// File: rtl/tx_dma_chan.sv
module tx_dma_chan
  import tx_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [4:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [4:0]          mem_len_o,
  output logic [31:0]         mem_wdata_o,
  input  logic                mem_gnt_i,
  input  logic                mem_rvalid_i,
  input  logic [31:0]         mem_rdata_i,
  output logic                tx_valid_o,
  input  logic                tx_ready_i,
  output logic [31:0]         tx_data_o,
  output logic                tx_last_o,
  output logic                done_irq_o,
  output logic                end_irq_o
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [ADDR_W-1:0] ptr, ptr_nxt;
  logic              run_q, swap, eng_idle, ptr_upd, eng_end;
  logic [1:0]        burst;
  logic              push, fifo_empty;
  logic [WORD_W:0]   push_data, head;
  logic [CW-1:0]     fifo_count;

  tx_dma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .eng_idle_i (eng_idle),
    .ptr_upd_i  (ptr_upd),
    .ptr_nxt_i  (ptr_nxt),
    .eng_end_i  (eng_end),
    .ptr_o      (ptr),
    .run_o      (run_q),
    .burst_o    (burst),
    .swap_o     (swap)
  );

  tx_dma_engine #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)) u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_q),
    .ptr_i        (ptr),
    .burst_i      (burst),
    .swap_i       (swap),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_len_o    (mem_len_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .fifo_count_i (fifo_count),
    .push_o       (push),
    .push_data_o  (push_data),
    .idle_o       (eng_idle),
    .ptr_upd_o    (ptr_upd),
    .ptr_nxt_o    (ptr_nxt),
    .end_o        (eng_end),
    .done_irq_o   (done_irq_o),
    .end_irq_o    (end_irq_o)
  );

  tx_dma_fifo #(.W(WORD_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pdata_i (push_data),
    .pop_i   (tx_valid_o && tx_ready_i),
    .head_o  (head),
    .empty_o (fifo_empty),
    .count_o (fifo_count)
  );

  assign tx_valid_o = !fifo_empty;
  assign tx_data_o  = head[WORD_W-1:0];
  assign tx_last_o  = head[WORD_W];
endmodule

// File: rtl/tx_dma_chan_chk.sv
module tx_dma_chan_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_i,
  input logic              mem_we_i,
  input logic              mem_gnt_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic [4:0]        mem_len_i,
  input logic [31:0]       mem_wdata_i,
  input logic              tx_valid_i,
  input logic              tx_ready_i,
  input logic [31:0]       tx_data_i,
  input logic              tx_last_i,
  input logic              done_i,
  input logic              end_i,
  input logic              run_i
);
  assert_irq_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i && end_i));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_end_stops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |-> !run_i);

  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_gnt_i) |=> (mem_req_i && $stable(mem_addr_i) && $stable(mem_len_i) && $stable(mem_we_i)));

  assert_len_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_we_i) |-> (mem_len_i >= 5'd1 && mem_len_i <= 5'd16));

  assert_wb_form_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_we_i) |-> (mem_wdata_i[1:0] == 2'b00 && mem_len_i == 5'd1));

  assert_tx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && !tx_ready_i) |=> (tx_valid_i && $stable(tx_data_i) && $stable(tx_last_i)));
endmodule

bind tx_dma_chan tx_dma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_i   (mem_req_o),
  .mem_we_i    (mem_we_o),
  .mem_gnt_i   (mem_gnt_i),
  .mem_addr_i  (mem_addr_o),
  .mem_len_i   (mem_len_o),
  .mem_wdata_i (mem_wdata_o),
  .tx_valid_i  (tx_valid_o),
  .tx_ready_i  (tx_ready_i),
  .tx_data_i   (tx_data_o),
  .tx_last_i   (tx_last_o),
  .done_i      (done_irq_o),
  .end_i       (end_irq_o),
  .run_i       (run_q)
);

// File: tb/tx_dma_chan_test.sv
`timescale 1ns/1ps
module tx_dma_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [4:0]  mem_len;
  logic        tx_valid, tx_ready, tx_last, done_irq, end_irq;
  logic [31:0] tx_data;

  always #2 clk = ~clk;

  tx_dma_chan uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_len_o(mem_len),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data), .tx_last_o(tx_last),
    .done_irq_o(done_irq), .end_irq_o(end_irq)
  );

  logic [31:0] mem [256];
  int checks = 0, errors = 0;
  logic [32:0] exp_q[$];
  logic [31:0] exp_adr_q[$];
  int          exp_len_q[$];
  int done_cnt = 0, end_cnt = 0;
  bit hold_ready = 1'b0;

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model, acts on falling edges
  initial begin
    int left;
    logic [7:0] idx;
    logic [31:0] ea;
    int el;
    left = 0; idx = '0;
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_gnt = 1'b0; mem_rvalid = 1'b0; left = 0;
      end else begin
        mem_rvalid = 1'b0;
        if (mem_gnt) mem_gnt = 1'b0;
        else if (left > 0) begin
          mem_rvalid = 1'b1; mem_rdata = mem[idx]; idx = idx + 8'd1; left--;
        end else if (mem_req) begin
          mem_gnt = 1'b1;
          if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
          else begin
            left = int'(mem_len); idx = mem_addr[9:2];
            checks++;
            if (exp_adr_q.size() == 0) begin
              errors++;
              $display("FAIL R5 unexpected read act=%h/%0d exp=none", mem_addr, mem_len);
            end else begin
              ea = exp_adr_q.pop_front(); el = exp_len_q.pop_front();
              if (mem_addr !== ea || int'(mem_len) != el) begin
                errors++;
                $display("FAIL R5 read act=%h/%0d exp=%h/%0d", mem_addr, mem_len, ea, el);
              end
            end
          end
        end
      end
    end
  end

  // ready driver, changes just after the rising edge
  initial begin
    logic [7:0] lf;
    lf = 8'hA5; tx_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      tx_ready = hold_ready ? 1'b0 : (lf[0] | lf[1]);
    end
  end

  // stream monitor and pulse counter
  initial begin
    logic [32:0] e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done_irq) done_cnt++;
        if (end_irq)  end_cnt++;
        if (tx_valid && tx_ready) begin
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R6 unexpected word act=%h exp=none", tx_data);
          end else begin
            e = exp_q.pop_front();
            if ({tx_last, tx_data} !== e) begin
              errors++;
              $display("FAIL R6/R7 word act=%h exp=%h", {tx_last, tx_data}, e);
            end
          end
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic put_desc(input int a, input logic [1:0] own, input int len, input int nxt, input int bf);
    mem[a >> 2]       = {len[15:0], 14'b0, own};
    mem[(a >> 2) + 1] = nxt;
    mem[(a >> 2) + 2] = bf;
    mem[(a >> 2) + 3] = 32'hFEED_0000 | a;
  endtask

  task automatic exp_fetch(input int a);
    exp_adr_q.push_back(a); exp_len_q.push_back(4);
  endtask

  // driver: fills the buffer and queues expected reads and words
  task automatic exp_pkt(input int bf, input int len, input int bw, input bit sw);
    int rem, ad;
    logic [31:0] w;
    for (int i = 0; i < len; i++) begin
      w = {bf[7:0] ^ 8'h3C, i[7:0], 8'hA0 | i[3:0], bf[9:2]};
      mem[(bf >> 2) + i] = w;
      exp_q.push_back({i == len - 1, sw ? bswap(w) : w});
    end
    rem = len; ad = bf;
    while (rem > 0) begin
      int n;
      n = (rem < bw) ? rem : bw;
      exp_adr_q.push_back(ad); exp_len_q.push_back(n);
      ad += 4 * n; rem -= n;
    end
  endtask

  task automatic wait_for(input int dn, input int en);
    int n;
    n = 0;
    while ((done_cnt < dn || end_cnt < en) && n < 5000) begin @(negedge clk); n++; end
    repeat (30) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 req in reset", {31'b0, mem_req}, 0);
    chk("R1 irq in reset", {30'b0, done_irq, end_irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid after reset", {31'b0, tx_valid}, 0);
    rd(5'h00, d); chk("R1 ptr reset", d, 0);
    rd(5'h04, d); chk("R1 run reset", d, 0);
    rd(5'h0C, d); chk("R1 burst reset", d, 0);

    // R2 register map
    wr(5'h0C, 32'hFFFF_FFFE); rd(5'h0C, d); chk("R2 burst reg", d, 32'd2);
    wr(5'h18, 32'h3);          rd(5'h18, d); chk("R2 swap reg", d, 32'd1);
    rd(5'h08, d); chk("R2 unmapped", d, 0);
    wr(5'h18, 0); wr(5'h0C, 0);

    // R3 R5 R6 R8 R4: two packets, then a software-owned descriptor
    put_desc(32'h00, 2'd1, 5, 32'h10, 32'h100);
    put_desc(32'h10, 2'd1, 9, 32'h20, 32'h140);
    put_desc(32'h20, 2'd0, 3, 32'h30, 32'h180);
    exp_fetch(32'h00); exp_pkt(32'h100, 5, 4, 1'b0);
    exp_fetch(32'h10); exp_pkt(32'h140, 9, 4, 1'b0);
    exp_fetch(32'h20);
    wr(5'h00, 32'h00); wr(5'h04, 1);
    wait_for(2, 1);
    chk("R8 done pulses", done_cnt, 2);
    chk("R4 end pulses", end_cnt, 1);
    rd(5'h00, d); chk("R4 ptr held on unowned", d, 32'h20);
    rd(5'h04, d); chk("R4 stopped", d, 0);
    chk("R8 writeback d0", mem[0], {16'd5, 16'd0});
    chk("R8 writeback d1", mem[4], {16'd9, 16'd0});
    chk("R6 stream drained", exp_q.size(), 0);

    // R4 resume on same descriptor, R7 swap, burst of 8
    put_desc(32'h20, 2'd1, 3, 32'h30, 32'h180);
    put_desc(32'h30, 2'd0, 0, 32'h40, 32'h200);
    wr(5'h0C, 1); wr(5'h18, 1);
    exp_fetch(32'h20); exp_pkt(32'h180, 3, 8, 1'b1);
    exp_fetch(32'h30);
    wr(5'h04, 1);
    wait_for(3, 2);
    chk("R4 resumed packet done", done_cnt, 3);
    rd(5'h00, d); chk("R4 ptr after resume", d, 32'h30);
    chk("R7 swapped stream drained", exp_q.size(), 0);

    // R5 burst 16 with a shortened tail
    wr(5'h0C, 2); wr(5'h18, 0);
    put_desc(32'h30, 2'd1, 20, 32'h40, 32'h200);
    put_desc(32'h40, 2'd0, 0, 32'h50, 32'h300);
    exp_fetch(32'h30); exp_pkt(32'h200, 20, 16, 1'b0);
    exp_fetch(32'h40);
    wr(5'h04, 1);
    wait_for(4, 3);
    chk("R5 long packet done", done_cnt, 4);
    chk("R5 reads consumed", exp_len_q.size(), 0);

    // R9 ignored pointer write, R10 stop mid packet
    wr(5'h0C, 0);
    put_desc(32'h40, 2'd1, 6, 32'h50, 32'h300);
    put_desc(32'h50, 2'd1, 2, 32'h60, 32'h340);
    exp_fetch(32'h40); exp_pkt(32'h300, 6, 4, 1'b0);
    hold_ready = 1'b1;
    wr(5'h04, 1);
    repeat (30) @(negedge clk);
    wr(5'h00, 32'h80);
    rd(5'h00, d); chk("R9 ptr write ignored", d, 32'h40);
    wr(5'h04, 0);
    rd(5'h04, d); chk("R10 run cleared", d, 0);
    chk("R10 packet pending", done_cnt, 4);
    hold_ready = 1'b0;
    wait_for(5, 3);
    repeat (40) @(negedge clk);
    chk("R10 packet finished", done_cnt, 5);
    chk("R10 no end pulse", end_cnt, 3);
    rd(5'h00, d); chk("R10 ptr at next", d, 32'h50);
    chk("R10 next not fetched", exp_len_q.size(), 0);
    chk("R10 next untouched", mem[32'h50 >> 2], {16'd2, 16'd1});

    // R11 zero length, R9 write accepted when stopped
    put_desc(32'h60, 2'd1, 0, 32'h70, 32'h380);
    put_desc(32'h70, 2'd0, 0, 32'h80, 32'h380);
    wr(5'h00, 32'h60);
    rd(5'h00, d); chk("R9 ptr write accepted", d, 32'h60);
    exp_fetch(32'h60); exp_fetch(32'h70);
    wr(5'h04, 1);
    wait_for(6, 4);
    chk("R11 done on empty", done_cnt, 6);
    chk("R11 end after", end_cnt, 4);
    chk("R11 writeback", mem[32'h60 >> 2], 32'h0);
    chk("R11 no words", exp_q.size(), 0);
    rd(5'h00, d); chk("R11 ptr", d, 32'h70);

    summary();
    $finish;
  end
endmodule